// File: doc/BRIEF.md
# Systolic 8-Point Inverse DCT

This block turns a vector of eight signed frequency-domain coefficients into eight spatial samples with a one-dimensional inverse DCT. It is meant as the first pass of a row/column two-dimensional transform. Coefficients arrive one per clock in natural order, and a start flag marks the first one. When the eighth coefficient has been taken, the vector is handed to a chain of four multiply-accumulate elements. Each element reads its cosine constant from a small constant table.

The transform is split into an even part and an odd part. The even part uses coefficients 0, 2, 4 and 6. The odd part uses coefficients 1, 3, 5 and 7. Each of the four elements owns one even/odd coefficient pair. A token carrying a partial sum enters the chain every cycle, alternating between an even half and an odd half for output index n. The token collects one product in each element. When the odd half leaves the last element, a butterfly forms sample n as E+O and sample 7−n as E−O. Both samples are rounded and presented together, so one output pair appears every other cycle.

Vectors may follow each other with no idle cycle. Each element keeps its own copy of its coefficient pair, loaded one cycle later than the element before it, so a new vector can be collected while the old one is still in the chain.

Top module: `idct8_systolic`

## Requirements
- R1: Reset is synchronous and active low. While it is held, and after it is released, out_valid stays 0 until a new vector has been fully accepted. A vector that is still inside the chain when reset is applied produces no output.
- R2: A coefficient taken with in_valid=1 and in_start=1 is coefficient 0. The next seven taken coefficients are 1 to 7 in order. An in_start during a partly collected vector discards the earlier part, and only the restarted vector produces output.
- R3: Each accepted vector yields four output pairs, with out_sel going 0, 1, 2, 3. The pair with out_sel=n carries sample n on out_a and sample 7−n on out_b.
- R4: Each sample is within 1 of y[n] = Σk 0.5·c(k)·X[k]·cos((2n+1)kπ/16), with c(0)=1/√2 and c(k)=1 otherwise. The output is a 15-bit two's-complement integer, rounded half up from five fraction bits. This holds for vectors with every |X[k]| ≤ 255, and for vectors with a single non-zero coefficient anywhere in −2048..2047.
- R5: The pair with out_sel=0 is valid in the seventh cycle after the edge that takes coefficient 7. Later pairs follow at a spacing of two cycles, and out_valid is never high in two consecutive cycles.
- R6: Vectors fed with no idle cycle between them are all transformed without loss. The pair with out_sel=3 of each vector is valid 13 cycles after that vector's coefficient 7 is taken.
- R7: Cycles with in_valid=0 are ignored, including their in_start and in_coef values. A vector with idle gaps between its coefficients gives the same result as a gap-free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_coef holds a coefficient this cycle |
| in_start | input | 1 | With in_valid, marks coefficient 0 of a vector |
| in_coef | input | 12 | Signed coefficient |
| out_valid | output | 1 | An output pair is present |
| out_sel | output | 2 | Pair index n |
| out_a | output | 15 | Signed sample n |
| out_b | output | 15 | Signed sample 7−n |

## Verification
The hardest case to reach from the ports is two vectors overlapping inside the chain. This happens when the next vector's coefficient registers reload while the last tokens of the previous vector are still in the later elements. The stimulus produces it by streaming six vectors with no idle cycle between them. The vectors have different magnitude and sign patterns, including full-range single coefficients, so a wrong reload skew shows up as a wrong value in a specific later pair. Gapped input, a restarted vector and a reset taken while a vector is in flight are each driven as separate directed sequences.

// File: rtl/idct8_pkg.sv
// Package: shared widths and the cosine constant table for the 8-point IDCT.
// Assumes constants are 0.5*c(k)*cos(...) scaled by 2^ROM_FRAC.
package idct8_pkg;
    localparam int COEF_W     = 12;
    localparam int ROM_W      = 13;
    localparam int ROM_FRAC   = 12;
    localparam int PSUM_W     = 19;
    localparam int SUM_FRAC   = 5;
    localparam int OUT_W      = 15;
    localparam int N_PE       = 4;
    localparam int VEC_LEN    = 2 * N_PE;
    localparam int PROD_W     = COEF_W + ROM_W;
    localparam int PROD_SHIFT = ROM_FRAC - SUM_FRAC;
    localparam int CNT_W      = $clog2(VEC_LEN);
    localparam int SEL_W      = $clog2(N_PE);

    localparam int K_A = 1448;  // 0.5*cos(pi/4)
    localparam int K_B = 1892;  // 0.5*cos(pi/8)
    localparam int K_C = 784;   // 0.5*cos(3pi/8)
    localparam int K_D = 2009;  // 0.5*cos(pi/16)
    localparam int K_E = 1703;  // 0.5*cos(3pi/16)
    localparam int K_F = 1138;  // 0.5*cos(5pi/16)
    localparam int K_G = 400;   // 0.5*cos(7pi/16)

    // Constant for element pe, output index n, even (odd=0) or odd half.
    function automatic logic signed [ROM_W-1:0] cos_rom(input int pe,
                                                        input logic [SEL_W-1:0] n,
                                                        input logic odd);
        int v;
        v = 0;
        if (!odd) begin
            case (pe)
                0: v = K_A;
                1: case (n) 2'd0: v = K_B; 2'd1: v = K_C; 2'd2: v = -K_C; default: v = -K_B; endcase
                2: case (n) 2'd0: v = K_A; 2'd1: v = -K_A; 2'd2: v = -K_A; default: v = K_A; endcase
                default: case (n) 2'd0: v = K_C; 2'd1: v = -K_B; 2'd2: v = K_B; default: v = -K_C; endcase
            endcase
        end else begin
            case (pe)
                0: case (n) 2'd0: v = K_D; 2'd1: v = K_E; 2'd2: v = K_F; default: v = K_G; endcase
                1: case (n) 2'd0: v = K_E; 2'd1: v = -K_G; 2'd2: v = -K_D; default: v = -K_F; endcase
                2: case (n) 2'd0: v = K_F; 2'd1: v = -K_D; 2'd2: v = K_G; default: v = K_E; endcase
                default: case (n) 2'd0: v = K_G; 2'd1: v = -K_F; 2'd2: v = K_E; default: v = -K_D; endcase
            endcase
        end
        return ROM_W'(v);
    endfunction
endpackage

// File: rtl/idct8_collect.sv
// Collects eight coefficients, hands a full vector to the array bank and
// issues eight tokens (n = 0..3, even then odd half) on the following cycles.
// Assumes a new vector completes no sooner than eight cycles after the last.
module idct8_collect
    import idct8_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic                            in_start,
    input  logic signed [COEF_W-1:0]        in_coef,
    output logic [VEC_LEN-1:0][COEF_W-1:0]  bank,
    output logic                            accept_last,
    output logic                            tok_v,
    output logic [SEL_W-1:0]                tok_n,
    output logic                            tok_odd
);
    logic [CNT_W-1:0]                cnt;
    logic [CNT_W-1:0]                idx;
    logic [CNT_W-1:0]                tok_cnt;
    logic [VEC_LEN-2:0][COEF_W-1:0]  col;

    assign idx         = in_start ? '0 : cnt;
    assign accept_last = in_valid && (idx == CNT_W'(VEC_LEN - 1));
    assign tok_odd     = tok_cnt[0];
    assign tok_n       = tok_cnt[CNT_W-1:1];

    // Position of the next coefficient within the vector.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (in_valid) cnt <= idx + 1'b1;
    end

    // Hold coefficients 0..6 until the last one arrives.
    always_ff @(posedge clk) begin
        if (in_valid && !accept_last) col[idx] <= in_coef;
    end

    // Transfer the complete vector into the bank read by the array.
    always_ff @(posedge clk) begin
        if (accept_last) begin
            for (int k = 0; k < VEC_LEN - 1; k++) bank[k] <= col[k];
            bank[VEC_LEN-1] <= in_coef;
        end
    end

    // Token sequencer: eight tokens per accepted vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_v   <= 1'b0;
            tok_cnt <= '0;
        end else if (accept_last) begin
            tok_v   <= 1'b1;
            tok_cnt <= '0;
        end else if (tok_v) begin
            tok_cnt <= tok_cnt + 1'b1;
            if (tok_cnt == CNT_W'(VEC_LEN - 1)) tok_v <= 1'b0;
        end
    end
endmodule

// File: rtl/idct8_pe.sv
// One multiply-accumulate element of the chain: adds x*cos to the incoming
// partial sum, truncating the product to the partial-sum scale, and passes
// the token to the next element one cycle later.
module idct8_pe
    import idct8_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic [SEL_W-1:0]         n_in,
    input  logic                     odd_in,
    input  logic signed [PSUM_W-1:0] ps_in,
    input  logic signed [COEF_W-1:0] x_even,
    input  logic signed [COEF_W-1:0] x_odd,
    output logic                     v_out,
    output logic [SEL_W-1:0]         n_out,
    output logic                     odd_out,
    output logic signed [PSUM_W-1:0] ps_out
);
    logic signed [COEF_W-1:0] x_sel;
    logic signed [ROM_W-1:0]  coef;
    logic signed [PROD_W-1:0] prod;
    logic signed [PSUM_W-1:0] term;

    assign x_sel = odd_in ? x_odd : x_even;
    assign coef  = cos_rom(IDX, n_in, odd_in);
    assign prod  = x_sel * coef;
    assign term  = PSUM_W'(prod >>> PROD_SHIFT);

    // Token valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v_in;
    end

    // Token tag and accumulated partial sum.
    always_ff @(posedge clk) begin
        n_out   <= n_in;
        odd_out <= odd_in;
        ps_out  <= ps_in + term;
    end
endmodule

// File: rtl/idct8_post.sv
// Butterfly and rounding: keeps the even half, then on the odd half emits
// sample n = E+O and sample 7-n = E-O, both rounded half up to integers.
module idct8_post
    import idct8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v,
    input  logic [SEL_W-1:0]         n,
    input  logic                     odd,
    input  logic signed [PSUM_W-1:0] ps,
    output logic                     out_valid,
    output logic [SEL_W-1:0]         out_sel,
    output logic signed [OUT_W-1:0]  out_a,
    output logic signed [OUT_W-1:0]  out_b
);
    localparam int HALF = 1 << (SUM_FRAC - 1);

    logic signed [PSUM_W-1:0] even_q;
    logic signed [PSUM_W:0]   s_add;
    logic signed [PSUM_W:0]   s_sub;

    function automatic logic signed [OUT_W-1:0] rnd(input logic signed [PSUM_W:0] s);
        logic signed [PSUM_W:0] t;
        t = (s + (PSUM_W + 1)'(HALF)) >>> SUM_FRAC;
        return OUT_W'(t);
    endfunction

    assign s_add = $signed({even_q[PSUM_W-1], even_q}) + $signed({ps[PSUM_W-1], ps});
    assign s_sub = $signed({even_q[PSUM_W-1], even_q}) - $signed({ps[PSUM_W-1], ps});

    // Capture the even half of the current pair.
    always_ff @(posedge clk) begin
        if (v && !odd) even_q <= ps;
    end

    // Output valid flag: one pulse per completed odd half.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v && odd;
    end

    // Output pair registers.
    always_ff @(posedge clk) begin
        if (v && odd) begin
            out_sel <= n;
            out_a   <= rnd(s_add);
            out_b   <= rnd(s_sub);
        end
    end
endmodule

// File: rtl/idct8_systolic.sv
// Top: collector, four chained multiply-accumulate elements and butterfly.
// Element j uses coefficients 2j and 2j+1. Element 0 reads the bank
// directly; element j>0 holds a private copy loaded j cycles after the bank,
// so an overlapping next vector cannot disturb tokens still in flight.
module idct8_systolic
    import idct8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_start,
    input  logic signed [COEF_W-1:0] in_coef,
    output logic                     out_valid,
    output logic [SEL_W-1:0]         out_sel,
    output logic signed [OUT_W-1:0]  out_a,
    output logic signed [OUT_W-1:0]  out_b
);
    logic [VEC_LEN-1:0][COEF_W-1:0] bank;
    logic                           accept_last;
    logic                           v_c   [N_PE+1];
    logic [SEL_W-1:0]               n_c   [N_PE+1];
    logic                           odd_c [N_PE+1];
    logic signed [PSUM_W-1:0]       ps_c  [N_PE+1];
    logic [N_PE-1:1]                ld_q;

    idct8_collect u_col (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_coef(in_coef), .bank(bank), .accept_last(accept_last),
        .tok_v(v_c[0]), .tok_n(n_c[0]), .tok_odd(odd_c[0])
    );

    assign ps_c[0] = '0;

    // Skewed load strobes for the private coefficient copies.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= {ld_q[N_PE-2:1], accept_last};
    end

    for (genvar j = 0; j < N_PE; j++) begin : g_pe
        logic signed [COEF_W-1:0] xe;
        logic signed [COEF_W-1:0] xo;
        if (j == 0) begin : g_direct
            assign xe = bank[0];
            assign xo = bank[1];
        end else begin : g_held
            // Reload this element's pair as the first token of a vector arrives.
            always_ff @(posedge clk) begin
                if (ld_q[j]) begin
                    xe <= bank[2*j];
                    xo <= bank[2*j+1];
                end
            end
        end
        idct8_pe #(.IDX(j)) u_pe (
            .clk(clk), .rst_n(rst_n),
            .v_in(v_c[j]), .n_in(n_c[j]), .odd_in(odd_c[j]), .ps_in(ps_c[j]),
            .x_even(xe), .x_odd(xo),
            .v_out(v_c[j+1]), .n_out(n_c[j+1]), .odd_out(odd_c[j+1]), .ps_out(ps_c[j+1])
        );
    end

    idct8_post u_post (
        .clk(clk), .rst_n(rst_n), .v(v_c[N_PE]), .n(n_c[N_PE]), .odd(odd_c[N_PE]),
        .ps(ps_c[N_PE]), .out_valid(out_valid), .out_sel(out_sel),
        .out_a(out_a), .out_b(out_b)
    );
endmodule

// File: rtl/idct8_checker.sv
// Checker: output ordering, spacing and latency properties of idct8_systolic.
module idct8_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       accept_last,
    input logic       out_valid,
    input logic [1:0] out_sel
);
    // R1: no output in the cycle after a reset edge.
    p_idle_after_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R5: pairs are never in consecutive cycles.
    p_pair_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5: first pair seven cycles after the last coefficient is taken.
    p_first_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_last |-> ##7 (out_valid && out_sel == 2'd0));

    // R3: pair indices step by one, two cycles apart.
    p_sel_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel != 2'd3) |-> ##2 (out_valid && out_sel == $past(out_sel, 2) + 2'd1));

    // R6: every accepted vector reaches its fourth pair.
    p_last_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_last |-> ##13 (out_valid && out_sel == 2'd3));
endmodule

bind idct8_systolic idct8_checker u_chk (
    .clk(clk), .rst_n(rst_n), .accept_last(accept_last),
    .out_valid(out_valid), .out_sel(out_sel)
);

// File: tb/sim_idct8_systolic.sv
// Bench: table of vectors streamed back to back, then directed tests for
// reset, gapped input, restart and reset in flight.
module sim_idct8_systolic;
    localparam real PI = 3.14159265358979;
    localparam int NT = 6;
    localparam int TBL [NT][8] = '{
        '{255, 0, 0, 0, 0, 0, 0, 0},
        '{-2048, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 2047},
        '{255, -255, 128, -77, 33, -200, 17, -5},
        '{50, -50, 50, -50, 50, -50, 50, -50},
        '{-120, 90, -255, 190, -3, 64, 255, -128}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_start = 1'b0;
    logic signed [11:0] in_coef = '0;
    logic               out_valid;
    logic [1:0]         out_sel;
    logic signed [14:0] out_a;
    logic signed [14:0] out_b;

    idct8_systolic u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_coef(in_coef), .out_valid(out_valid), .out_sel(out_sel),
        .out_a(out_a), .out_b(out_b)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int g_sel [64];
    int g_a   [64];
    int g_b   [64];
    int g_cyc [64];
    int gcount = 0;
    int e_vec [16][8];
    int e_k   [16];
    int ecount = 0;
    int vv [8];

    // Record every output pair, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && gcount < 64) begin
            g_sel[gcount] = int'(out_sel);
            g_a[gcount]   = int'(out_a);
            g_b[gcount]   = int'(out_b);
            g_cyc[gcount] = cyc;
            gcount++;
        end
    end

    task automatic check(input bit ok, input string req, input real act, input real expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0f expected %0f", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
        end
    endtask

    // Drive one vector from vv; gap idle cycles carry junk that must be ignored.
    task automatic feed(input int gap);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (k == 0);
            in_coef  = 12'(vv[k]);
            if (k == 7) begin
                for (int j = 0; j < 8; j++) e_vec[ecount][j] = vv[j];
                e_k[ecount] = cyc;
                ecount++;
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b1;
                in_coef  = 12'sh5a5;
            end
        end
    endtask

    function automatic real ref_y(input int e, input int n);
        real s;
        s = 0.0;
        for (int k = 0; k < 8; k++)
            s += 0.5 * ((k == 0) ? 1.0 / $sqrt(2.0) : 1.0) * real'(e_vec[e][k])
                 * $cos(real'((2 * n + 1) * k) * PI / 16.0);
        return s;
    endfunction

    function automatic real absr(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    // Compare recorded pairs against the expectation list.
    task automatic verify(input string tag);
        real ya;
        real yb;
        for (int i = 0; i < gcount; i++) begin
            int e = i / 4;
            int p = i % 4;
            if (e < ecount) begin
                ya = ref_y(e, p);
                yb = ref_y(e, 7 - p);
                check(g_sel[i] == p, {"R3 pair index ", tag}, g_sel[i], p);
                check(g_cyc[i] == e_k[e] + 7 + 2 * p, {"R5 pair timing ", tag}, g_cyc[i], e_k[e] + 7 + 2 * p);
                check(absr(real'(g_a[i]) - ya) <= 1.0, {"R4 sample n ", tag}, g_a[i], ya);
                check(absr(real'(g_b[i]) - yb) <= 1.0, {"R3 R4 sample 7-n ", tag}, g_b[i], yb);
            end
        end
        check(gcount == 4 * ecount, {"R6 pair count ", tag}, gcount, 4 * ecount);
    endtask

    initial begin
        // R1: junk input while reset is held.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_coef  = 12'sh123;
        end
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        in_start = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        idle(14);
        check(gcount == 0, "R1 no pairs from reset junk", gcount, 0);

        // R6: table vectors back to back.
        gcount = 0; ecount = 0;
        for (int i = 0; i < NT; i++) begin
            for (int k = 0; k < 8; k++) vv[k] = TBL[i][k];
            feed(0);
        end
        idle(20);
        verify("R6 back-to-back");

        // R7: gaps with junk in_start/in_coef between coefficients.
        gcount = 0; ecount = 0;
        vv = '{-90, 31, 200, -7, 15, -180, 66, 120};
        feed(2);
        idle(20);
        check(gcount == 4, "R7 gapped vector pairs", gcount, 4);
        verify("R7 gapped");

        // R2: partial vector restarted by a new start flag.
        gcount = 0; ecount = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (k == 0);
            in_coef  = 12'sh3e7;
        end
        vv = '{12, 240, -60, 0, -255, 9, -33, 101};
        feed(0);
        idle(20);
        check(gcount == 4, "R2 restart pairs", gcount, 4);
        verify("R2 restart");

        // R1: reset while a vector is in flight.
        gcount = 0; ecount = 0;
        vv = '{200, 100, -100, 50, 25, -25, 10, -10};
        feed(0);
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        @(negedge clk);
        rst_n = 1'b1;
        idle(20);
        check(gcount == 0, "R1 in-flight vector dropped", gcount, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected 0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule